// File: doc/BRIEF.md
# Rectangle Overlay Stage for a Chained Video Pipeline

This block is one stage in a chain of identical video stages that pass an 8-bit 4:2:2 component byte stream along with its side-band: a frame-start pulse, the line number, the byte position within the line and three sync flags (field, vertical blank, horizontal blank). Every signal passes through exactly one register, so any number of stages can be chained and stay aligned. Each stage that is enabled overlays a solid rectangle of one colour on whatever the stream carries from upstream. A stage later in the chain therefore paints over the stages before it.

The rectangle has inclusive left/right bounds on byte position and top/bottom bounds on line number. The fill colour is given as separate luma, blue-difference and red-difference values. The stage reads these seven inputs only on a frame-start byte and holds them in shadow registers. As a result, an object that software moves between frames never tears inside a frame. Inside the rectangle the stage picks the right component for each byte position, so the component order of the stream is kept.

Top module: `vid_rect_overlay`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: `frame_start_o`, `line_num_o`, `pix_pos_o` and `sync_flags_o` equal the corresponding inputs from one clock earlier. All three flag bits, including the field bit [2], pass through unmodified.
- R3: When `en` is low, `vid_o` equals `vid_i` from one clock earlier.
- R4: When the byte is outside the held rectangle, or either blanking flag is set (`sync_flags_i[1]` vertical, `sync_flags_i[0]` horizontal), `vid_o` equals `vid_i` from one clock earlier.
- R5: An enabled, unblanked byte inside the rectangle is replaced one clock later by the held fill colour. If `pix_pos_i[0]`=1 the byte becomes luma. If `pix_pos_i[1:0]`=00 it becomes blue difference. If `pix_pos_i[1:0]`=10 it becomes red difference.
- R6: The bounds are inclusive. Positions equal to left and right, and lines equal to top and bottom, are inside. Position left-1 or right+1, and line top-1 or bottom+1, are outside.
- R7: Bounds and colour are captured only at an edge where `frame_start_i` is high. The byte that carries that pulse still uses the previous values. Changes to these inputs at any other time have no effect.
- R8: After reset and before the first frame-start pulse, the held rectangle is empty, so the stage is transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Overlay enable |
| vid_i | input | 8 | Incoming video byte |
| frame_start_i | input | 1 | Frame-start pulse |
| line_num_i | input | 10 | Line number |
| pix_pos_i | input | 11 | Byte position in line |
| sync_flags_i | input | 3 | {field, vertical blank, horizontal blank} |
| win_left_i | input | 11 | Rectangle left bound (inclusive) |
| win_right_i | input | 11 | Rectangle right bound (inclusive) |
| win_top_i | input | 10 | Rectangle top line (inclusive) |
| win_bottom_i | input | 10 | Rectangle bottom line (inclusive) |
| fill_luma_i | input | 8 | Fill luma |
| fill_cb_i | input | 8 | Fill blue difference |
| fill_cr_i | input | 8 | Fill red difference |
| vid_o | output | 8 | Outgoing video byte |
| frame_start_o | output | 1 | Delayed frame-start |
| line_num_o | output | 10 | Delayed line number |
| pix_pos_o | output | 11 | Delayed byte position |
| sync_flags_o | output | 3 | Delayed sync flags |

## Verification
The bench walks across every edge of the rectangle, one position and one line on each side. An off-by-one compare would paint a column or row too many, or drop one. It places bytes at all four phases of position modulo four. A swapped component select would turn the fill into a wrong colour or a striped pattern. It changes the bound and colour inputs in the middle of a frame and on the frame-start byte itself. A design that loads continuously, or that applies the new values to the pulse byte, would move the rectangle early. Blanked bytes, disabled bytes and bytes seen before the first frame-start must come through untouched. Random traffic with occasional new frames covers the remaining mixes.

// File: rtl/vro_pkg.sv
package vro_pkg;
   localparam int VID_W_DEF  = 8;
   localparam int LINE_W_DEF = 10;
   localparam int POS_W_DEF  = 11;
   localparam int FLAG_W     = 3;
   // Flag bit positions, decoded by neighbouring stages
   localparam int FLAG_FIELD = 2;
   localparam int FLAG_VBLK  = 1;
   localparam int FLAG_HBLK  = 0;

   typedef enum logic [1:0] {
      COMP_CB   = 2'd0,
      COMP_LUMA = 2'd1,
      COMP_CR   = 2'd2
   } comp_e;
endpackage

// File: rtl/vro_shadow.sv
module vro_shadow #(
   parameter int VID_W  = 8,
   parameter int LINE_W = 10,
   parameter int POS_W  = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [POS_W-1:0]  left_i,
   input  logic [POS_W-1:0]  right_i,
   input  logic [LINE_W-1:0] top_i,
   input  logic [LINE_W-1:0] bottom_i,
   input  logic [VID_W-1:0]  luma_i,
   input  logic [VID_W-1:0]  cb_i,
   input  logic [VID_W-1:0]  cr_i,
   output logic [POS_W-1:0]  left_q,
   output logic [POS_W-1:0]  right_q,
   output logic [LINE_W-1:0] top_q,
   output logic [LINE_W-1:0] bottom_q,
   output logic [VID_W-1:0]  luma_q,
   output logic [VID_W-1:0]  cb_q,
   output logic [VID_W-1:0]  cr_q
);
   // Reset value is an empty window: left above right, top below bottom
   always_ff @(posedge clk) begin
      if (rst) begin
         left_q   <= '1;
         right_q  <= '0;
         top_q    <= '1;
         bottom_q <= '0;
         luma_q   <= '0;
         cb_q     <= '0;
         cr_q     <= '0;
      end else if (load) begin
         left_q   <= left_i;
         right_q  <= right_i;
         top_q    <= top_i;
         bottom_q <= bottom_i;
         luma_q   <= luma_i;
         cb_q     <= cb_i;
         cr_q     <= cr_i;
      end
   end
endmodule

// File: rtl/vro_window.sv
module vro_window #(
   parameter int LINE_W = 10,
   parameter int POS_W  = 11
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [POS_W-1:0]  left_i,
   input  logic [POS_W-1:0]  right_i,
   input  logic [LINE_W-1:0] top_i,
   input  logic [LINE_W-1:0] bottom_i,
   output logic              hit_o
);
   logic in_x, in_y;
   always_comb begin
      in_x  = (pos_i  >= left_i) && (pos_i  <= right_i);
      in_y  = (line_i >= top_i)  && (line_i <= bottom_i);
      hit_o = in_x && in_y;
   end
endmodule

// File: rtl/vro_colour_pick.sv
module vro_colour_pick
   import vro_pkg::*;
#(
   parameter int VID_W    = 8,
   parameter int POS_W    = 11,
   parameter bit CB_FIRST = 1'b1
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic [VID_W-1:0] luma_i,
   input  logic [VID_W-1:0] cb_i,
   input  logic [VID_W-1:0] cr_i,
   output logic [VID_W-1:0] byte_o
);
   comp_e sel;

   generate
      if (CB_FIRST) begin : g_cb_first
         always_comb begin
            if (pos_i[0])      sel = COMP_LUMA;
            else if (pos_i[1]) sel = COMP_CR;
            else               sel = COMP_CB;
         end
      end else begin : g_cr_first
         always_comb begin
            if (pos_i[0])      sel = COMP_LUMA;
            else if (pos_i[1]) sel = COMP_CB;
            else               sel = COMP_CR;
         end
      end
   endgenerate

   always_comb begin
      unique case (sel)
         COMP_LUMA: byte_o = luma_i;
         COMP_CR:   byte_o = cr_i;
         default:   byte_o = cb_i;
      endcase
   end
endmodule

// File: rtl/vid_rect_overlay.sv
module vid_rect_overlay
   import vro_pkg::*;
#(
   parameter int VID_W    = VID_W_DEF,
   parameter int LINE_W   = LINE_W_DEF,
   parameter int POS_W    = POS_W_DEF,
   parameter bit CB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [VID_W-1:0]  vid_i,
   input  logic              frame_start_i,
   input  logic [LINE_W-1:0] line_num_i,
   input  logic [POS_W-1:0]  pix_pos_i,
   input  logic [2:0]        sync_flags_i,
   input  logic [POS_W-1:0]  win_left_i,
   input  logic [POS_W-1:0]  win_right_i,
   input  logic [LINE_W-1:0] win_top_i,
   input  logic [LINE_W-1:0] win_bottom_i,
   input  logic [VID_W-1:0]  fill_luma_i,
   input  logic [VID_W-1:0]  fill_cb_i,
   input  logic [VID_W-1:0]  fill_cr_i,
   output logic [VID_W-1:0]  vid_o,
   output logic              frame_start_o,
   output logic [LINE_W-1:0] line_num_o,
   output logic [POS_W-1:0]  pix_pos_o,
   output logic [2:0]        sync_flags_o
);
   localparam int MAX_POS  = (1 << POS_W) - 1;
   localparam int MAX_LINE = (1 << LINE_W) - 1;

   // Elaboration-time parameter checks
   if (VID_W < 1)       begin : g_bad_vid  $error("VID_W must be at least 1");  end
   if (POS_W < 2)       begin : g_bad_pos  $error("POS_W must be at least 2");  end
   if (LINE_W < 1)      begin : g_bad_line $error("LINE_W must be at least 1"); end
   if (MAX_POS < 1439)  begin : g_small_p  $error("POS_W too narrow for a line"); end
   if (MAX_LINE < 575)  begin : g_small_l  $error("LINE_W too narrow for a frame"); end

   logic [POS_W-1:0]  h_left, h_right;
   logic [LINE_W-1:0] h_top, h_bottom;
   logic [VID_W-1:0]  h_luma, h_cb, h_cr;
   logic              hit;
   logic [VID_W-1:0]  fill_byte;
   logic              blanked;
   logic              paint;
   logic [VID_W-1:0]  vid_next;

   vro_shadow #(.VID_W(VID_W), .LINE_W(LINE_W), .POS_W(POS_W)) u_shadow (
      .clk      (clk),
      .rst      (rst),
      .load     (frame_start_i),
      .left_i   (win_left_i),
      .right_i  (win_right_i),
      .top_i    (win_top_i),
      .bottom_i (win_bottom_i),
      .luma_i   (fill_luma_i),
      .cb_i     (fill_cb_i),
      .cr_i     (fill_cr_i),
      .left_q   (h_left),
      .right_q  (h_right),
      .top_q    (h_top),
      .bottom_q (h_bottom),
      .luma_q   (h_luma),
      .cb_q     (h_cb),
      .cr_q     (h_cr)
   );

   vro_window #(.LINE_W(LINE_W), .POS_W(POS_W)) u_window (
      .line_i   (line_num_i),
      .pos_i    (pix_pos_i),
      .left_i   (h_left),
      .right_i  (h_right),
      .top_i    (h_top),
      .bottom_i (h_bottom),
      .hit_o    (hit)
   );

   vro_colour_pick #(.VID_W(VID_W), .POS_W(POS_W), .CB_FIRST(CB_FIRST)) u_pick (
      .pos_i  (pix_pos_i),
      .luma_i (h_luma),
      .cb_i   (h_cb),
      .cr_i   (h_cr),
      .byte_o (fill_byte)
   );

   always_comb begin
      blanked  = sync_flags_i[FLAG_VBLK] | sync_flags_i[FLAG_HBLK];
      paint    = en & hit & ~blanked;
      vid_next = paint ? fill_byte : vid_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vid_o         <= '0;
         frame_start_o <= 1'b0;
         line_num_o    <= '0;
         pix_pos_o     <= '0;
         sync_flags_o  <= '0;
      end else begin
         vid_o         <= vid_next;
         frame_start_o <= frame_start_i;
         line_num_o    <= line_num_i;
         pix_pos_o     <= pix_pos_i;
         sync_flags_o  <= sync_flags_i;
      end
   end
endmodule

// File: rtl/vro_checker.sv
module vro_checker #(
   parameter int VID_W  = 8,
   parameter int LINE_W = 10,
   parameter int POS_W  = 11
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic [VID_W-1:0]  vid_i,
   input logic              frame_start_i,
   input logic [LINE_W-1:0] line_num_i,
   input logic [POS_W-1:0]  pix_pos_i,
   input logic [2:0]        sync_flags_i,
   input logic [VID_W-1:0]  vid_o,
   input logic              frame_start_o,
   input logic [LINE_W-1:0] line_num_o,
   input logic [POS_W-1:0]  pix_pos_o,
   input logic [2:0]        sync_flags_o
);
   logic seen_start;
   always_ff @(posedge clk) begin
      if (rst)                seen_start <= 1'b0;
      else if (frame_start_i) seen_start <= 1'b1;
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (vid_o == '0 && !frame_start_o && line_num_o == '0));

   p_side_delay_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (line_num_o == $past(line_num_i) && pix_pos_o == $past(pix_pos_i)
                && sync_flags_o == $past(sync_flags_i)
                && frame_start_o == $past(frame_start_i)));

   p_disabled_pass_r3: assert property (@(posedge clk) disable iff (rst)
      !en |=> vid_o == $past(vid_i));

   p_blank_pass_r4: assert property (@(posedge clk) disable iff (rst)
      (sync_flags_i[1] || sync_flags_i[0]) |=> vid_o == $past(vid_i));

   p_empty_before_start_r8: assert property (@(posedge clk) disable iff (rst)
      !seen_start |=> vid_o == $past(vid_i));
endmodule

bind vid_rect_overlay vro_checker #(.VID_W(VID_W), .LINE_W(LINE_W), .POS_W(POS_W)) u_vro_chk (
   .clk           (clk),
   .rst           (rst),
   .en            (en),
   .vid_i         (vid_i),
   .frame_start_i (frame_start_i),
   .line_num_i    (line_num_i),
   .pix_pos_i     (pix_pos_i),
   .sync_flags_i  (sync_flags_i),
   .vid_o         (vid_o),
   .frame_start_o (frame_start_o),
   .line_num_o    (line_num_o),
   .pix_pos_o     (pix_pos_o),
   .sync_flags_o  (sync_flags_o)
);

// File: tb/vid_rect_overlay_tb_top.sv
`timescale 1ns/1ps
module vid_rect_overlay_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic [7:0]  vid_i = '0;
   logic        frame_start_i = 1'b0;
   logic [9:0]  line_num_i = '0;
   logic [10:0] pix_pos_i = '0;
   logic [2:0]  sync_flags_i = '0;
   logic [10:0] win_left_i = '0, win_right_i = '0;
   logic [9:0]  win_top_i = '0, win_bottom_i = '0;
   logic [7:0]  fill_luma_i = '0, fill_cb_i = '0, fill_cr_i = '0;
   logic [7:0]  vid_o;
   logic        frame_start_o;
   logic [9:0]  line_num_o;
   logic [10:0] pix_pos_o;
   logic [2:0]  sync_flags_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // Bench-side held rectangle and colour (reset: empty)
   logic [10:0] m_left = '1, m_right = '0;
   logic [9:0]  m_top = '1, m_bottom = '0;
   logic [7:0]  m_luma = '0, m_cb = '0, m_cr = '0;
   bit          m_started = 1'b0;

   always #2 clk = ~clk;

   vid_rect_overlay dut_i (
      .clk(clk), .rst(rst), .en(en), .vid_i(vid_i), .frame_start_i(frame_start_i),
      .line_num_i(line_num_i), .pix_pos_i(pix_pos_i), .sync_flags_i(sync_flags_i),
      .win_left_i(win_left_i), .win_right_i(win_right_i), .win_top_i(win_top_i),
      .win_bottom_i(win_bottom_i), .fill_luma_i(fill_luma_i), .fill_cb_i(fill_cb_i),
      .fill_cr_i(fill_cr_i), .vid_o(vid_o), .frame_start_o(frame_start_o),
      .line_num_o(line_num_o), .pix_pos_o(pix_pos_o), .sync_flags_o(sync_flags_o)
   );

   function automatic bit inside_win(logic [9:0] ln, logic [10:0] sp);
      return (sp >= m_left) && (sp <= m_right) && (ln >= m_top) && (ln <= m_bottom);
   endfunction

   function automatic logic [7:0] fill_for(logic [10:0] sp);
      if (sp[0])      return m_luma;
      else if (sp[1]) return m_cr;
      else            return m_cb;
   endfunction

   function automatic logic [7:0] exp_vid(logic e, logic [2:0] fl, logic [9:0] ln,
                                          logic [10:0] sp, logic [7:0] px);
      if (e && !fl[1] && !fl[0] && inside_win(ln, sp)) return fill_for(sp);
      return px;
   endfunction

   function automatic string tag_for(logic e, logic [2:0] fl, logic [9:0] ln, logic [10:0] sp);
      if (!m_started)                  return "R8";
      if (!e)                          return "R3";
      if (fl[1] || fl[0])              return "R4";
      if (inside_win(ln, sp))          return "R5";
      return "R4";
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
      end
   endtask

   // One clock: predict from current inputs, step, compare outputs.
   task automatic cyc(string force_tag = "");
      logic [7:0]  ev;
      logic [9:0]  el;
      logic [10:0] ep;
      logic [2:0]  ef;
      logic        et;
      string       tg;
      ev = exp_vid(en, sync_flags_i, line_num_i, pix_pos_i, vid_i);
      el = line_num_i; ep = pix_pos_i; ef = sync_flags_i; et = frame_start_i;
      tg = (force_tag != "") ? force_tag : tag_for(en, sync_flags_i, line_num_i, pix_pos_i);
      @(posedge clk);
      if (frame_start_i) begin
         m_left = win_left_i; m_right = win_right_i; m_top = win_top_i;
         m_bottom = win_bottom_i; m_luma = fill_luma_i; m_cb = fill_cb_i;
         m_cr = fill_cr_i; m_started = 1'b1;
      end
      #1;
      check(vid_o == ev, tg, vid_o, ev);
      check(line_num_o == el && pix_pos_o == ep && sync_flags_o == ef && frame_start_o == et,
            "R2", {frame_start_o, sync_flags_o, line_num_o, pix_pos_o},
            {et, ef, el, ep});
   endtask

   task automatic drive(logic [9:0] ln, logic [10:0] sp, logic [7:0] px, logic [2:0] fl);
      line_num_i = ln; pix_pos_i = sp; vid_i = px; sync_flags_i = fl;
   endtask

   task automatic set_win(int l, int r, int t, int b, int y, int cb, int cr);
      win_left_i = 11'(l); win_right_i = 11'(r); win_top_i = 10'(t); win_bottom_i = 10'(b);
      fill_luma_i = 8'(y); fill_cb_i = 8'(cb); fill_cr_i = 8'(cr);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual 1 expected 0 (run hung)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      int unused;
      unused = $urandom(32'h5EED_0042);
      // R1: reset clears outputs
      drive(10'd7, 11'd9, 8'h3C, 3'b100);
      frame_start_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(vid_o == 8'h00 && !frame_start_o && line_num_o == '0 && pix_pos_o == '0
            && sync_flags_o == '0, "R1", {vid_o, line_num_o}, 0);
      frame_start_i = 1'b0;
      rst = 1'b0;
      en  = 1'b1;

      // R8: window inputs set but no frame-start yet -> transparent
      set_win(100, 103, 10, 12, 8'hEB, 8'h55, 8'hAA);
      drive(10'd11, 11'd101, 8'h10, 3'b000); cyc("R8");
      drive(10'd11, 11'd102, 8'h11, 3'b100); cyc("R8");

      // R7: pulse byte itself still transparent; capture at this edge
      drive(10'd11, 11'd101, 8'h12, 3'b000);
      frame_start_i = 1'b1; cyc("R7");
      frame_start_i = 1'b0;
      // R7: mid-frame changes ignored
      set_win(0, 1439, 0, 575, 8'h01, 8'h02, 8'h03);

      // R6 / R5: edges and all four phases
      for (int s = 99; s <= 104; s++) begin
         drive(10'd10, 11'(s), 8'(8'h40 + s), 3'b000); cyc("R6");
         drive(10'd12, 11'(s), 8'(8'h50 + s), 3'b000); cyc("R6");
      end
      drive(10'd9,  11'd101, 8'h61, 3'b000); cyc("R6");
      drive(10'd13, 11'd101, 8'h62, 3'b000); cyc("R6");
      for (int s = 100; s <= 103; s++) begin
         drive(10'd11, 11'(s), 8'h77, 3'b100); cyc("R5");
      end
      drive(10'd0, 11'd0, 8'h63, 3'b000); cyc("R7");

      // R4 blanking, R3 disable inside window
      drive(10'd11, 11'd101, 8'h70, 3'b010); cyc("R4");
      drive(10'd11, 11'd102, 8'h71, 3'b001); cyc("R4");
      en = 1'b0;
      drive(10'd11, 11'd100, 8'h72, 3'b000); cyc("R3");
      drive(10'd11, 11'd101, 8'h73, 3'b000); cyc("R3");
      en = 1'b1;

      // New frame picks up the mid-frame values (full screen)
      drive(10'd0, 11'd0, 8'h80, 3'b000);
      frame_start_i = 1'b1; cyc("R7");
      frame_start_i = 1'b0;
      drive(10'd300, 11'd700, 8'h81, 3'b000); cyc("R7");

      // Constrained random traffic
      for (int i = 0; i < 20000; i++) begin
         logic [9:0]  ln;
         logic [10:0] sp;
         logic [2:0]  fl;
         if ($urandom_range(1)) begin
            ln = 10'($urandom_range(575));
            sp = 11'($urandom_range(1439));
         end else begin
            ln = 10'((int'(m_top) > 575 ? 0 : int'(m_top)) + $urandom_range(8));
            sp = 11'((int'(m_left) > 1439 ? 0 : int'(m_left)) + $urandom_range(8));
         end
         fl = {1'($urandom_range(1)), ($urandom_range(7) == 0), ($urandom_range(7) == 0)};
         drive(ln, sp, 8'($urandom), fl);
         en = ($urandom_range(9) != 0);
         if ($urandom_range(15) == 0) begin
            int l, t;
            l = $urandom_range(1400);
            t = $urandom_range(560);
            set_win(l, l + $urandom_range(30), t, t + $urandom_range(12),
                    $urandom, $urandom, $urandom);
         end
         frame_start_i = ($urandom_range(199) == 0);
         cyc();
      end
      frame_start_i = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule